// File: doc/BRIEF.md
# Slow Clock Frequency Monitor

This block watches a nominal 32.768 kHz clock from inside a trusted reference clock domain and flags it when its frequency is wrong. The monitored clock is brought into the reference domain through a two-flop synchroniser. The block then counts reference cycles between successive rising edges and tests each count against a window of about ±10% around the nominal period. The window is scaled to the reference frequency chosen on `ref_sel` (4, 8 or 12 MHz).

An isolated bad period is tolerated. Only a run of four rejected periods in a row raises a sticky error flag. If the clock stops, no edge arrives, so the counter times out just past the upper limit, and each timeout counts as a rejected period. The flag can be cleared only by dropping `mon_en`. The flag always drives a reset request, and it drives an interrupt only when `irq_en` is set.

The block starts monitoring only when `mon_en` and `ref_stable` are both high. The window limits are captured at that moment. To use a new reference range, software must stop the monitor, wait for the reference to report stable, and then enable the monitor again.

Top module: `slowclk_freq_mon`

## Requirements
- R1: After reset `err_flag`, `irq` and `rst_req` are 0.
- R2: With `ref_sel` = 1 (8 MHz) a period is the number of reference cycles between successive rising edges of the synchronised monitored clock. Periods of 220 to 268 cycles are accepted; 219 and 269 are rejected.
- R3: With `ref_sel` = 0 (4 MHz) the accepted range is 110 to 134 cycles. With `ref_sel` = 2 or 3 (12 MHz) it is 330 to 402 cycles.
- R4: `err_flag` rises after 4 consecutive rejected periods. Three in a row do not raise it, and any accepted period restarts the run.
- R5: Once set, `err_flag` stays 1 while `mon_en` is 1. It returns to 0 one cycle after `mon_en` is sampled low.
- R6: The first rising edge after monitoring starts only begins a measurement and is never judged.
- R7: If no rising edge arrives within upper-limit-plus-one cycles, that interval counts as rejected and measurement restarts at the next edge. A stopped clock therefore sets `err_flag` after four timeouts.
- R8: Monitoring starts only on a cycle where `mon_en` and `ref_stable` are both 1. While it waits, no period is judged.
- R9: The limits are captured from `ref_sel` when monitoring starts. A later change of `ref_sel` has no effect until the monitor is disabled and started again.
- R10: `irq` is 1 exactly when `err_flag` and `irq_en` are both 1.
- R11: `rst_req` follows `err_flag` regardless of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitor enable; low clears the error |
| ref_stable | input | 1 | Reference oscillator reports stable frequency |
| ref_sel | input | 2 | Reference range: 0 = 4 MHz, 1 = 8 MHz, 2/3 = 12 MHz |
| slow_clk_in | input | 1 | Raw monitored clock, asynchronous |
| irq_en | input | 1 | Interrupt enable |
| err_flag | output | 1 | Sticky frequency error |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | Reset request to the reset controller |

## Verification
The assertions assume that each high and low phase of the monitored clock lasts at least two reference cycles, so that every rising edge survives the synchroniser as one pulse. They also assume that `mon_en`, `ref_sel` and `ref_stable` are synchronous to the reference clock. The stimulus drives every input on the falling reference edge. Its shortest period is half the 4 MHz lower limit, so no phase is shorter than 27 cycles. Every long period stays below twice the upper limit plus one, so one monitored period yields exactly one judgment.

// File: rtl/slowclk_freq_mon.sv
module slowclk_freq_mon #(
  parameter int LO_BASE = 110,
  parameter int HI_BASE = 134,
  parameter int BAD_RUN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mon_en,
  input  logic       ref_stable,
  input  logic [1:0] ref_sel,
  input  logic       slow_clk_in,
  input  logic       irq_en,
  output logic       err_flag,
  output logic       irq,
  output logic       rst_req
);
  localparam int CW = $clog2(3 * HI_BASE + 2);
  localparam int BW = $clog2(BAD_RUN + 1);

  logic [2:0]    sync_q;
  logic          active, armed;
  logic [CW-1:0] cnt, lo_q, hi_q, lo_sel, hi_sel;
  logic [BW-1:0] bad_cnt;
  logic          rise, timeout, judge, bad;

  always_comb begin
    case (ref_sel)
      2'd0:    begin lo_sel = CW'(LO_BASE);     hi_sel = CW'(HI_BASE);     end
      2'd1:    begin lo_sel = CW'(2 * LO_BASE); hi_sel = CW'(2 * HI_BASE); end
      default: begin lo_sel = CW'(3 * LO_BASE); hi_sel = CW'(3 * HI_BASE); end
    endcase
  end

  assign rise    = sync_q[1] & ~sync_q[2];
  assign timeout = active && !rise && (cnt == hi_q + CW'(1));
  assign judge   = active && ((rise && armed) || timeout);
  assign bad     = judge && (timeout || cnt < lo_q || cnt > hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], slow_clk_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !mon_en) begin
      active   <= 1'b0;
      armed    <= 1'b0;
      cnt      <= '0;
      bad_cnt  <= '0;
      err_flag <= 1'b0;
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end
    end else if (!active) begin
      if (ref_stable) begin
        active <= 1'b1;
        lo_q   <= lo_sel;
        hi_q   <= hi_sel;
        cnt    <= CW'(1);
      end
    end else begin
      if (rise) begin
        cnt   <= CW'(1);
        armed <= 1'b1;
      end else if (timeout) begin
        cnt   <= CW'(1);
        armed <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
      if (judge) begin
        if (bad) begin
          if (bad_cnt != BW'(BAD_RUN)) bad_cnt <= bad_cnt + BW'(1);
          if (bad_cnt >= BW'(BAD_RUN - 1)) err_flag <= 1'b1;
        end else begin
          bad_cnt <= '0;
        end
      end
    end
  end

  assign irq     = err_flag & irq_en;
  assign rst_req = err_flag;

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && mon_en) |=> err_flag);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !err_flag);
  a_r4_run_before_err: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> ($past(bad_cnt) >= BW'(BAD_RUN - 1)));
  a_r4_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt <= BW'(BAD_RUN));
  a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt <= hi_q + CW'(1)));
  a_r8_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(mon_en && ref_stable));
  a_r9_limits_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(active) && active) |-> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: tb/slowclk_freq_mon_tb.sv
module slowclk_freq_mon_tb;
  logic clk = 1'b0, rst_n = 1'b0, mon_en = 1'b0, ref_stable = 1'b1;
  logic [1:0] ref_sel = 2'd1;
  logic slow_clk_in = 1'b0, irq_en = 1'b0;
  logic err_flag, irq, rst_req;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  slowclk_freq_mon u_dut (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .ref_stable(ref_stable),
    .ref_sel(ref_sel), .slow_clk_in(slow_clk_in), .irq_en(irq_en),
    .err_flag(err_flag), .irq(irq), .rst_req(rst_req));

  function automatic int mult(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 2 : 3;
  endfunction
  function automatic bit in_win(int p, int sel);
    return p >= 110 * mult(sel) && p <= 134 * mult(sel);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic period(input int p);
    slow_clk_in = 1'b1;
    idle(p / 2);
    slow_clk_in = 1'b0;
    idle(p - p / 2);
  endtask

  task automatic restart(input int sel);
    mon_en = 1'b0;
    idle(2);
    ref_sel = 2'(sel);
    mon_en = 1'b1;
    idle(3);
  endtask

  task automatic try_run(input string req, input int sel, input int p, input logic exp);
    restart(sel);
    period(122 * mult(sel));
    repeat (5) period(p);
    period(122 * mult(sel));
    chk(req, err_flag, exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(4);
    chk("R1 err after reset", err_flag, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 rst_req after reset", rst_req, 1'b0);
    rst_n = 1'b1;
    idle(2);

    restart(1);
    repeat (8) period(244);
    chk("R2 nominal 8MHz", err_flag, 1'b0);
    try_run("R2 lower edge 220", 1, 220, 1'b0);
    try_run("R2 upper edge 268", 1, 268, 1'b0);
    try_run("R2 below 219", 1, 219, 1'b1);
    try_run("R2 above 269", 1, 269, 1'b1);
    try_run("R3 4MHz 110", 0, 110, 1'b0);
    try_run("R3 4MHz 134", 0, 134, 1'b0);
    try_run("R3 4MHz 109", 0, 109, 1'b1);
    try_run("R3 4MHz 135", 0, 135, 1'b1);
    try_run("R3 12MHz 330", 2, 330, 1'b0);
    try_run("R3 12MHz 402", 2, 402, 1'b0);
    try_run("R3 12MHz 329", 2, 329, 1'b1);
    try_run("R3 12MHz 403", 2, 403, 1'b1);
    try_run("R3 sel3 366", 3, 366, 1'b0);

    restart(1);
    period(244);
    repeat (3) period(200);
    repeat (2) period(244);
    repeat (3) period(200);
    period(244);
    chk("R4 three bad then reset", err_flag, 1'b0);
    repeat (4) period(200);
    period(244);
    chk("R4 four bad", err_flag, 1'b1);
    repeat (5) period(244);
    chk("R5 sticky", err_flag, 1'b1);
    irq_en = 1'b0;
    idle(1);
    chk("R10 irq masked", irq, 1'b0);
    chk("R11 rst_req unmasked", rst_req, 1'b1);
    irq_en = 1'b1;
    idle(1);
    chk("R10 irq enabled", irq, 1'b1);
    mon_en = 1'b0;
    idle(1);
    chk("R5 cleared by disable", err_flag, 1'b0);
    chk("R10 irq cleared", irq, 1'b0);
    chk("R11 rst_req cleared", rst_req, 1'b0);

    restart(1);
    repeat (3) period(200);
    repeat (3) period(244);
    chk("R6 first edge discarded", err_flag, 1'b0);

    restart(1);
    idle(800);
    chk("R7 stopped, under four timeouts", err_flag, 1'b0);
    idle(400);
    chk("R7 stopped clock detected", err_flag, 1'b1);

    mon_en = 1'b0;
    idle(2);
    ref_sel = 2'd1;
    ref_stable = 1'b0;
    mon_en = 1'b1;
    repeat (6) period(200);
    chk("R8 waits for ref_stable", err_flag, 1'b0);
    ref_stable = 1'b1;
    repeat (6) period(200);
    chk("R8 starts when stable", err_flag, 1'b1);

    restart(1);
    ref_sel = 2'd0;
    repeat (8) period(244);
    chk("R9 range change ignored", err_flag, 1'b0);
    mon_en = 1'b0;
    idle(2);
    mon_en = 1'b1;
    repeat (6) period(244);
    chk("R9 new range after restart", err_flag, 1'b1);

    for (int t = 0; t < 12; t++) begin
      int sel, lo, hi, run, p;
      logic e;
      sel = int'($urandom % 4);
      lo = 110 * mult(sel);
      hi = 134 * mult(sel);
      run = 0;
      e = 1'b0;
      restart(sel);
      for (int k = 0; k < 8; k++) begin
        case ($urandom % 3)
          0: p = lo + int'($urandom % (hi - lo + 1));
          1: p = lo - 1 - int'($urandom % (lo / 2));
          default: p = hi + 1 + int'($urandom % (hi - 10));
        endcase
        period(p);
        if (in_win(p, sel)) run = 0;
        else begin
          run++;
          if (run >= 4) e = 1'b1;
        end
      end
      period(122 * mult(sel));
      chk("R4 random sequence", err_flag, e);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule